// File: doc/BRIEF.md
# Double SHA-256 Nonce Search Engine

This block scans an inclusive range of 32-bit nonces for a proof-of-work hit. The caller gives it the compression state already reached after the first 64 header bytes, the 12 header bytes that come before the nonce, the two range limits, a 256-bit threshold and a job tag. For each nonce the engine finishes the header hash from that saved state. It then hashes the resulting 32-byte digest once more from the standard starting constants and compares the outcome with the threshold.

Each hit is offered on a valid/ready port that carries the nonce and the job tag. While a hit waits to be taken, the search is frozen, so no result can be overwritten. A fresh load throws away whatever is in progress, including a hit still waiting. A done flag marks the end of the range. The datapath does one compression round per clock, which gives a fixed cost of 130 cycles per nonce.

Top module: `nonce_search_engine`

## Requirements
- R1: After reset, `hit_valid`, `busy` and `done` are all low.
- R2: The first compression starts from `mid_in`, where bits [255:224] are the first state word. It uses this 16-word block: the three words of `tail_in` (bits [95:64] first), then the nonce with its bytes reversed, then 0x80000000, ten zero words, and the length 640. The second compression starts from the standard SHA-256 initial values. Its block is the 8 first-pass digest words, then 0x80000000, six zero words, and the length 256.
- R3: The final 32-byte digest is read as a little-endian integer, so its first byte is the least significant. A nonce is a hit only when that integer is strictly less than `target_in`. An all-ones target makes every nonce a hit, and a zero target makes none a hit.
- R4: Nonces from `start_in` to `end_in` inclusive are each checked once, in ascending order, and hits come out in that order. The search ends at `end_in` even when it is 0xFFFFFFFF. If `start_in` is greater than `end_in`, no nonce is checked and `done` is high in the cycle after the load.
- R5: Each hit carries its nonce on `hit_nonce` and the job tag of its load on `hit_job`.
- R6: Each nonce takes 130 cycles. The first hit is valid 130 clock edges after the loading edge. After a hit is accepted, the next nonce's result is ready 130 edges after the accepting edge.
- R7: While `hit_valid` is high and `hit_ready` is low, the hit and its fields stay unchanged and the search does not move on. After a hit is accepted, `hit_valid` is low in the next cycle.
- R8: A load in any state abandons the current search and any waiting hit. In the next cycle `hit_valid` is low, and every later hit belongs to the new job.
- R9: `done` rises once the last nonce has been checked and any hit for it has been accepted. It stays high until the next load, and while it is high `busy` and `hit_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Start a new job; aborts any current one |
| mid_in | input | 256 | Saved state after the first header block |
| tail_in | input | 96 | Header bytes 64..75 as three big-endian words |
| start_in | input | 32 | First nonce to check |
| end_in | input | 32 | Last nonce to check (inclusive) |
| target_in | input | 256 | Hit threshold (strict less-than) |
| job_in | input | JOB_W | Tag returned with each hit |
| hit_valid | output | 1 | A hit is offered |
| hit_ready | input | 1 | Consumer takes the hit |
| hit_nonce | output | 32 | Nonce of the offered hit |
| hit_job | output | JOB_W | Job tag of the offered hit |
| busy | output | 1 | A search or a pending hit is active |
| done | output | 1 | The range is finished |

## Verification
The hardest case to reach from the ports is an abort that lands exactly while a hit is waiting. A hit only appears after 130 cycles of hashing, and ordinary targets make it a matter of chance. The stimulus makes the hit certain with an all-ones target, holds `hit_ready` low so the hit stays pending, and then loads a new job. It checks that the old hit is gone in the next cycle and that the next hit carries the new job's nonce and tag. Threshold byte order and block layout are checked with targets that accept about half or a quarter of the nonces. The bench compares the reported nonces against its own full double-hash model.

// File: rtl/nonce_search_engine.sv
module nonce_search_engine #(
  parameter int JOB_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [255:0]     mid_in,
  input  logic [95:0]      tail_in,
  input  logic [31:0]      start_in,
  input  logic [31:0]      end_in,
  input  logic [255:0]     target_in,
  input  logic [JOB_W-1:0] job_in,
  output logic             hit_valid,
  input  logic             hit_ready,
  output logic [31:0]      hit_nonce,
  output logic [JOB_W-1:0] hit_job,
  output logic             busy,
  output logic             done
);

  localparam int          ROUNDS  = 64;
  localparam int          LASTR   = ROUNDS - 1;
  localparam logic [31:0] PAD_ONE = 32'h8000_0000;
  localparam logic [31:0] LEN_HDR = 32'd640;
  localparam logic [31:0] LEN_DIG = 32'd256;
  localparam logic [255:0] IV = {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                                 32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
  localparam logic [31:0] KT [ROUNDS] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_ADD, ST_HIT} st_t;

  function automatic logic [31:0] rotr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] bs32(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic logic [255:0] bs256(input logic [255:0] x);
    logic [255:0] r;
    for (int i = 0; i < 32; i++) r[8*i +: 8] = x[255-8*i -: 8];
    return r;
  endfunction

  function automatic logic [255:0] add8(input logic [255:0] x, input logic [255:0] y);
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[32*i +: 32] = x[32*i +: 32] + y[32*i +: 32];
    return r;
  endfunction

  function automatic logic [511:0] inner_blk(input logic [95:0] t, input logic [31:0] n);
    return {t, bs32(n), PAD_ONE, 320'd0, LEN_HDR};
  endfunction

  st_t                    st;
  logic                   outer;
  logic [5:0]             rnd;
  logic [0:7][31:0]       hv;
  logic [0:15][31:0]      win;
  logic [255:0]           mid_q, tgt_q;
  logic [95:0]            tail_q;
  logic [31:0]            nonce_q, end_q;
  logic [JOB_W-1:0]       job_q;
  logic                   done_q;

  logic [31:0]  t1, t2, ws0, ws1, wnext;
  logic [255:0] fin_le;
  logic         is_hit, adv;

  assign t1 = hv[7] + (rotr(hv[4], 6) ^ rotr(hv[4], 11) ^ rotr(hv[4], 25))
            + ((hv[4] & hv[5]) ^ (~hv[4] & hv[6])) + KT[rnd] + win[0];
  assign t2 = (rotr(hv[0], 2) ^ rotr(hv[0], 13) ^ rotr(hv[0], 22))
            + ((hv[0] & hv[1]) ^ (hv[0] & hv[2]) ^ (hv[1] & hv[2]));
  assign ws0   = rotr(win[1], 7) ^ rotr(win[1], 18) ^ (win[1] >> 3);
  assign ws1   = rotr(win[14], 17) ^ rotr(win[14], 19) ^ (win[14] >> 10);
  assign wnext = win[0] + ws0 + win[9] + ws1;

  assign fin_le = bs256(add8(IV, hv));
  assign is_hit = fin_le < tgt_q;
  assign adv    = (st == ST_ADD && outer && !is_hit) || (st == ST_HIT && hit_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      done_q <= 1'b0;
      outer  <= 1'b0;
      rnd    <= '0;
    end else if (load) begin
      mid_q   <= mid_in;
      tail_q  <= tail_in;
      tgt_q   <= target_in;
      job_q   <= job_in;
      end_q   <= end_in;
      nonce_q <= start_in;
      hv      <= mid_in;
      win     <= inner_blk(tail_in, start_in);
      outer   <= 1'b0;
      rnd     <= '0;
      if (start_in > end_in) begin
        st     <= ST_IDLE;
        done_q <= 1'b1;
      end else begin
        st     <= ST_RUN;
        done_q <= 1'b0;
      end
    end else if (adv) begin
      if (nonce_q == end_q) begin
        st     <= ST_IDLE;
        done_q <= 1'b1;
      end else begin
        nonce_q <= nonce_q + 32'd1;
        hv      <= mid_q;
        win     <= inner_blk(tail_q, nonce_q + 32'd1);
        outer   <= 1'b0;
        rnd     <= '0;
        st      <= ST_RUN;
      end
    end else begin
      case (st)
        ST_RUN: begin
          hv  <= {t1 + t2, hv[0], hv[1], hv[2], hv[3] + t1, hv[4], hv[5], hv[6]};
          win <= {win[1:15], wnext};
          rnd <= rnd + 6'd1;
          if (rnd == 6'(LASTR)) st <= ST_ADD;
        end
        ST_ADD: begin
          if (!outer) begin
            win   <= {add8(mid_q, hv), PAD_ONE, 192'd0, LEN_DIG};
            hv    <= IV;
            outer <= 1'b1;
            rnd   <= '0;
            st    <= ST_RUN;
          end else begin
            st <= ST_HIT;
          end
        end
        default: ;
      endcase
    end
  end

  assign hit_valid = (st == ST_HIT);
  assign hit_nonce = nonce_q;
  assign hit_job   = job_q;
  assign busy      = (st != ST_IDLE);
  assign done      = done_q;

  AST_HIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid && !hit_ready && !load |=> hit_valid && $stable(hit_nonce) && $stable(hit_job)); // R7
  AST_HIT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid && hit_ready && !load |=> !hit_valid); // R7
  AST_HIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> hit_nonce <= end_q); // R4
  AST_LOAD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !hit_valid); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !hit_valid); // R9
  AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    done && !load |=> done); // R9

endmodule

// File: tb/tb_nonce_search_engine.sv
`timescale 1ns/1ps
module tb_nonce_search_engine;

  localparam int JOB_W = 8;
  localparam logic [255:0] ONES = '1;
  localparam logic [255:0] MIDB = 256'h1f3a5c77_9e02b4d1_c8e6a013_5b7d9f24_0a6e3c88_d4f21b95_7c3e6a50_e19b2d46;
  localparam logic [95:0]  TAILB = 96'h4b1e39a2_5e6f70c1_17031977;
  localparam logic [255:0] IVB = {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                                  32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
  localparam logic [31:0] KB [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  // start, end, target select, stall cycles before accepting
  localparam logic [69:0] VT [6] = '{
    {32'd0,          32'd5,          2'd2, 4'd0},
    {32'd100,        32'd107,        2'd3, 4'd3},
    {32'd7,          32'd9,          2'd1, 4'd0},
    {32'd20,         32'd23,         2'd0, 4'd0},
    {32'hFFFF_FFFD,  32'hFFFF_FFFF,  2'd2, 4'd1},
    {32'd42,         32'd42,         2'd1, 4'd2}};

  logic clk = 1'b0, rst_n = 1'b0, load = 1'b0, hit_ready = 1'b0;
  logic [255:0] mid_in = '0, target_in = '0;
  logic [95:0] tail_in = '0;
  logic [31:0] start_in = '0, end_in = '0;
  logic [JOB_W-1:0] job_in = '0;
  logic hit_valid, busy, done;
  logic [31:0] hit_nonce;
  logic [JOB_W-1:0] hit_job;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  nonce_search_engine #(.JOB_W(JOB_W)) dut (
    .clk(clk), .rst_n(rst_n), .load(load), .mid_in(mid_in), .tail_in(tail_in),
    .start_in(start_in), .end_in(end_in), .target_in(target_in), .job_in(job_in),
    .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_nonce(hit_nonce),
    .hit_job(hit_job), .busy(busy), .done(done));

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] sha_blk(input logic [255:0] hin, input logic [511:0] blk);
    logic [31:0] w [64];
    logic [31:0] a, b, c, d, e, f, g, h, x1, x2;
    for (int t = 0; t < 16; t++) w[t] = blk[511-32*t -: 32];
    for (int t = 16; t < 64; t++)
      w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7]
           + (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
    {a, b, c, d, e, f, g, h} = hin;
    for (int t = 0; t < 64; t++) begin
      x1 = h + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + ((e & f) ^ (~e & g)) + KB[t] + w[t];
      x2 = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & b) ^ (a & c) ^ (b & c));
      h = g; g = f; f = e; e = d + x1; d = c; c = b; b = a; a = x1 + x2;
    end
    return {a + hin[255:224], b + hin[223:192], c + hin[191:160], d + hin[159:128],
            e + hin[127:96],  f + hin[95:64],   g + hin[63:32],   h + hin[31:0]};
  endfunction

  function automatic logic [255:0] dbl_le(input logic [255:0] m, input logic [95:0] t, input logic [31:0] n);
    logic [255:0] inner, outer, r;
    inner = sha_blk(m, {t, n[7:0], n[15:8], n[23:16], n[31:24], 32'h8000_0000, 320'd0, 32'd640});
    outer = sha_blk(IVB, {inner, 32'h8000_0000, 192'd0, 32'd256});
    for (int i = 0; i < 32; i++) r[8*i +: 8] = outer[255-8*i -: 8];
    return r;
  endfunction

  function automatic logic [255:0] tsel(input logic [1:0] s);
    case (s)
      2'd0: return '0;
      2'd1: return ONES;
      2'd2: return {1'b1, 255'd0};
      default: return {2'b01, 254'd0};
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [255:0] m, input logic [95:0] t, input logic [31:0] s,
                         input logic [31:0] e, input logic [255:0] tg, input logic [JOB_W-1:0] j);
    @(negedge clk);
    mid_in = m; tail_in = t; start_in = s; end_in = e; target_in = tg; job_in = j; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_hit(output int n);
    n = 0;
    while (!hit_valid && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic accept();
    hit_ready = 1'b1;
    @(negedge clk);
    hit_ready = 1'b0;
  endtask

  task automatic run_vec(input int idx);
    logic [31:0] s, e, expn [16];
    logic [255:0] tg, m;
    logic [95:0] t;
    logic [JOB_W-1:0] j;
    int stall, cnt, got, guard;
    s = VT[idx][69:38]; e = VT[idx][37:6]; tg = tsel(VT[idx][5:4]); stall = int'(VT[idx][3:0]);
    m = MIDB ^ 256'(idx * 32'h01010101); t = TAILB ^ 96'(idx); j = JOB_W'(idx + 16);
    cnt = 0;
    for (logic [32:0] n = {1'b0, s}; n <= {1'b0, e}; n++)
      if (dbl_le(m, t, n[31:0]) < tg) begin expn[cnt] = n[31:0]; cnt++; end
    do_load(m, t, s, e, tg, j);
    got = 0; guard = 0;
    while (!done && guard < 3000) begin
      if (hit_valid) begin
        chk(got < cnt && hit_nonce == expn[got], "R2,R3 nonce", 256'(hit_nonce),
            got < cnt ? 256'(expn[got]) : ONES);
        chk(hit_job == j, "R5 job", 256'(hit_job), 256'(j));
        for (int k = 0; k < stall; k++) begin
          @(negedge clk);
          chk(hit_valid && hit_nonce == (got < cnt ? expn[got] : hit_nonce), "R7 hold",
              256'(hit_nonce), 256'(got < cnt ? expn[got] : 32'd0));
        end
        accept();
        got++;
      end else begin
        @(negedge clk);
        guard++;
      end
    end
    chk(got == cnt, "R4 hit count", 256'(got), 256'(cnt));
    chk(done && !busy, "R9 done at end", 256'({done, busy}), 256'(2'b10));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!hit_valid && !busy && !done, "R1 reset", 256'({hit_valid, busy, done}), 256'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!hit_valid && !busy && !done, "R1 after release", 256'({hit_valid, busy, done}), 256'(0));

    // R2: reference model sanity on the three-byte message "abc"
    chk(sha_blk(IVB, {24'h616263, 8'h80, 416'd0, 64'd24}) ==
        256'hba7816bf_8f01cfea_414140de_5dae2223_b00361a3_96177a9c_b410ff61_f20015ad,
        "R2 model", sha_blk(IVB, {24'h616263, 8'h80, 416'd0, 64'd24}), 256'd0);

    for (int i = 0; i < 6; i++) run_vec(i);

    // R6: latency of first and following nonce
    do_load(MIDB, TAILB, 32'd500, 32'd501, ONES, 8'h33);
    wait_hit(n);
    chk(n == 130, "R6 first latency", 256'(n), 256'(130));
    chk(hit_nonce == 32'd500 && hit_job == 8'h33, "R5 first hit", 256'(hit_nonce), 256'(500));
    hit_ready = 1'b1;
    n = 0;
    @(negedge clk); n++;
    hit_ready = 1'b0;
    while (!hit_valid && n < 2000) begin @(negedge clk); n++; end
    chk(n == 131, "R6 next latency", 256'(n), 256'(131));
    chk(hit_nonce == 32'd501, "R4 ascending", 256'(hit_nonce), 256'(501));
    accept();
    chk(done && !busy, "R9 done after last accept", 256'({done, busy}), 256'(2'b10));
    repeat (10) @(negedge clk);
    chk(done && !hit_valid, "R9 done holds", 256'({done, hit_valid}), 256'(2'b10));

    // R4: empty range
    do_load(MIDB, TAILB, 32'd10, 32'd9, ONES, 8'h34);
    chk(done && !busy, "R4 empty range done", 256'({done, busy}), 256'(2'b10));
    n = 0;
    for (int k = 0; k < 140; k++) begin @(negedge clk); if (hit_valid) n++; end
    chk(n == 0, "R4 empty range no hit", 256'(n), 256'(0));

    // R8: abort during search
    do_load(MIDB, TAILB, 32'd0, 32'd3, ONES, 8'h41);
    chk(!done && busy, "R9 load clears done", 256'({done, busy}), 256'(2'b01));
    repeat (60) @(negedge clk);
    do_load(MIDB, TAILB, 32'd900, 32'd900, ONES, 8'h42);
    wait_hit(n);
    chk(n == 130 && hit_nonce == 32'd900 && hit_job == 8'h42, "R8 abort search",
        256'({n[15:0], hit_nonce, hit_job}), 256'({16'd130, 32'd900, 8'h42}));
    accept();

    // R8: abort while a hit is pending
    do_load(MIDB, TAILB, 32'd5, 32'd6, ONES, 8'h43);
    wait_hit(n);
    repeat (3) @(negedge clk);
    chk(hit_valid && hit_nonce == 32'd5, "R7 pending hit", 256'(hit_nonce), 256'(5));
    do_load(MIDB, TAILB, 32'd77, 32'd77, ONES, 8'h44);
    chk(!hit_valid, "R8 pending dropped", 256'(hit_valid), 256'(0));
    wait_hit(n);
    chk(hit_nonce == 32'd77 && hit_job == 8'h44, "R8 new job hit",
        256'({hit_nonce, hit_job}), 256'({32'd77, 8'h44}));
    accept();
    chk(done, "R9 final done", 256'(done), 256'(1));

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule